// File: doc/BRIEF.md
# Subtract and Compare ALU

A three-stage integer pipeline that computes a subtract-from result (second operand minus first operand) and signed compares of register against register or register against immediate. Every operation goes through one shared adder that forms B−A as the inverted first operand plus the second operand plus one. The first operand is never swapped against the second, so a compare sees B−A where its condition code is written in terms of A. The output stage corrects this by exchanging the positive and negative flags. That costs two single-bit multiplexers, where a swap at the operands would cost two full-width multiplexers.

One operation can enter each cycle, and its result leaves exactly three cycles later. A condition field for a compare holds less-than, greater-than and equal in its three upper bits, with the summary-overflow bit in bit 0. The field index travels with the result, so the field can be written to the correct one of eight condition fields. For a subtract-from with record enabled, the same field layout reports negative, positive and zero for the 64-bit result.

Top module: `sc_alu`

## Requirements
- R1: `valid_o` equals `valid_i` from three rising clock edges earlier. A new operation may enter every cycle, and the pipeline never stalls.
- R2: Opcode 0 (subtract-from) gives `diff_o` = `b_i` − `a_i` modulo 2^64. The `dword_i` bit has no effect on this result.
- R3: For opcode 0, `crf_we_o` equals `rc_i`. `crf_o` is {bit 63 of the result, result positive and nonzero, result zero, `so_i`}, with bit 3 first.
- R4: Opcodes 1 (register compare) and 2 (immediate compare) always assert `crf_we_o`. They set `crf_o[3:1]` to 3'b100 when A<B, 3'b010 when A>B and 3'b001 when A=B, using a signed comparison. `crf_o[0]` is `so_i`.
- R5: With `dword_i`=0, a compare uses bits 31:0 of each operand, sign-extended to 64 bits. With `dword_i`=1, it uses all 64 bits.
- R6: Opcode 2 replaces the second operand with `imm_i` sign-extended to 64 bits, and `b_i` is ignored.
- R7: The compare result is correct even when B−A overflows 64 bits, for example with operands at the most negative and most positive values.
- R8: `bf_o` equals the `bf_i` that entered with the same operation.
- R9: Opcode 3 is reserved. It produces a valid output slot with `crf_we_o` low.
- R10: While `rst_ni` is low, `valid_o` and `crf_we_o` are low.
- R11: `crf_we_o` is low whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 0 subtract-from, 1 compare, 2 compare immediate, 3 reserved |
| dword_i | input | 1 | 1: 64-bit compare, 0: 32-bit sign-extended compare |
| a_i | input | 64 | First operand (A) |
| b_i | input | 64 | Second operand (B) |
| imm_i | input | 16 | Signed immediate |
| bf_i | input | 3 | Target condition field index |
| rc_i | input | 1 | Record enable for subtract-from |
| so_i | input | 1 | Current summary-overflow bit |
| valid_o | output | 1 | Result present |
| diff_o | output | 64 | B − A of the operands as formed |
| crf_o | output | 4 | Condition field |
| bf_o | output | 3 | Target condition field index |
| crf_we_o | output | 1 | Condition field write enable |

## Verification
Because a new operation can enter every cycle, a compare and a recorded subtract-from can occupy adjacent stages. In that case the flag exchange in the output stage must act only on the compare, while the same main-stage flags drive the subtract-from in the cycle after. The bench causes this by streaming a seeded random mix of opcodes, with no gaps in most cycles. It checks each output slot against a model that computes the condition code straight from signed comparisons of the operands. Directed cases add overflowing compare pairs and word-mode operands whose upper bits are noise.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;
  localparam int unsigned BF_W = 3;

  typedef enum logic [1:0] {
    OP_SUBF = 2'd0,
    OP_CMP  = 2'd1,
    OP_CMPI = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef struct packed {
    logic            valid;
    op_e             op;
    logic [BF_W-1:0] bf;
    logic            rc;
    logic            so;
  } ctl_t;

  function automatic logic is_cmp(op_e op);
    return (op == OP_CMP) || (op == OP_CMPI);
  endfunction
endpackage

// File: rtl/sc_alu_in.sv
module sc_alu_in
  import sc_alu_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic             dword_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  output ctl_t             ctl_o,
  output logic [XLEN-1:0]  opa_o,
  output logic [XLEN-1:0]  opb_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] imm_ext, a_word, b_word, opa_d, opb_d;

  generate
    if (XLEN > IMM_W) begin : g_imm_ext
      assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_imm_trunc
      assign imm_ext = imm_i[XLEN-1:0];
    end
  endgenerate

  assign a_word = {{(XLEN-HALF){a_i[HALF-1]}}, a_i[HALF-1:0]};
  assign b_word = {{(XLEN-HALF){b_i[HALF-1]}}, b_i[HALF-1:0]};

  // subtract-from always full width; compares honour the mode bit
  always_comb begin
    opa_d = a_i;
    opb_d = b_i;
    if (is_cmp(ctl_i.op) && !dword_i) begin
      opa_d = a_word;
      opb_d = b_word;
    end
    if (ctl_i.op == OP_CMPI) opb_d = imm_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      opa_o <= '0;
      opb_o <= '0;
    end else begin
      ctl_o <= ctl_i;
      opa_o <= opa_d;
      opb_o <= opb_d;
    end
  end

  AST_S1_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.valid |=> ctl_o.valid); // R1
  AST_S1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.valid |=> !ctl_o.valid); // R1
endmodule

// File: rtl/sc_alu_main.sv
module sc_alu_main
  import sc_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output ctl_t            ctl_o,
  output logic [XLEN-1:0] res_o,
  output logic            neg_o,
  output logic            zero_o
);
  localparam int unsigned SW = XLEN + 1;

  logic [SW-1:0] sum;

  // one bit wider than the operands so compare sign survives overflow
  assign sum = {~opa_i[XLEN-1], ~opa_i} + {opb_i[XLEN-1], opb_i}
             + {{XLEN{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      res_o  <= '0;
      neg_o  <= 1'b0;
      zero_o <= 1'b0;
    end else begin
      ctl_o  <= ctl_i;
      res_o  <= sum[XLEN-1:0];
      neg_o  <= is_cmp(ctl_i.op) ? sum[SW-1] : sum[XLEN-1];
      zero_o <= ~|sum[XLEN-1:0];
    end
  end

  AST_S2_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.valid |=> ctl_o.valid); // R1
  AST_S2_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.valid |=> !ctl_o.valid); // R1
  AST_EQUAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.valid && opa_i == opb_i) |=> zero_o && !neg_o); // R4
endmodule

// File: rtl/sc_alu_out.sv
module sc_alu_out
  import sc_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  input  logic [XLEN-1:0] res_i,
  input  logic            neg_i,
  input  logic            zero_i,
  output logic            valid_o,
  output logic [XLEN-1:0] diff_o,
  output logic [3:0]      crf_o,
  output logic [BF_W-1:0] bf_o,
  output logic            crf_we_o
);
  logic pos, cmp, hi_bit, mid_bit, we_d;

  assign pos = !neg_i && !zero_i;
  assign cmp = is_cmp(ctl_i.op);

  // B-A sign is reversed against the A-relative compare code: swap here
  assign hi_bit  = cmp ? pos   : neg_i;
  assign mid_bit = cmp ? neg_i : pos;
  assign we_d    = ctl_i.valid && (cmp || (ctl_i.op == OP_SUBF && ctl_i.rc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      diff_o   <= '0;
      crf_o    <= '0;
      bf_o     <= '0;
      crf_we_o <= 1'b0;
    end else begin
      valid_o  <= ctl_i.valid;
      diff_o   <= res_i;
      crf_o    <= {hi_bit, mid_bit, zero_i, ctl_i.so};
      bf_o     <= ctl_i.bf;
      crf_we_o <= we_d;
    end
  end

  AST_WE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crf_we_o |-> valid_o); // R11
  AST_CMP_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.valid && cmp) |=> crf_we_o); // R4
  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.op == OP_RSVD) |=> !crf_we_o); // R9
  AST_CODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crf_we_o |-> $countones(crf_o[3:1]) == 1); // R4
  AST_BF_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.valid |=> bf_o == $past(ctl_i.bf)); // R8
  AST_EQ_ZERO_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crf_we_o && crf_o[1]) |-> diff_o == '0); // R3
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_alu_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             dword_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [2:0]       bf_i,
  input  logic             rc_i,
  input  logic             so_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  diff_o,
  output logic [3:0]       crf_o,
  output logic [2:0]       bf_o,
  output logic             crf_we_o
);
  ctl_t            ctl_in, ctl_s1, ctl_s2;
  logic [XLEN-1:0] opa_s1, opb_s1, res_s2;
  logic            neg_s2, zero_s2;

  assign ctl_in = '{valid: valid_i, op: op_e'(op_i), bf: bf_i, rc: rc_i, so: so_i};

  sc_alu_in #(.XLEN(XLEN), .IMM_W(IMM_W)) i_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_in),
    .dword_i (dword_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .imm_i   (imm_i),
    .ctl_o   (ctl_s1),
    .opa_o   (opa_s1),
    .opb_o   (opb_s1)
  );

  sc_alu_main #(.XLEN(XLEN)) i_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_s1),
    .opa_i  (opa_s1),
    .opb_i  (opb_s1),
    .ctl_o  (ctl_s2),
    .res_o  (res_s2),
    .neg_o  (neg_s2),
    .zero_o (zero_s2)
  );

  sc_alu_out #(.XLEN(XLEN)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl_s2),
    .res_i    (res_s2),
    .neg_i    (neg_s2),
    .zero_i   (zero_s2),
    .valid_o  (valid_o),
    .diff_o   (diff_o),
    .crf_o    (crf_o),
    .bf_o     (bf_o),
    .crf_we_o (crf_we_o)
  );
endmodule

// File: tb/test_sc_alu.sv
`timescale 1ns/1ps
module test_sc_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        dword_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic [2:0]  bf_i = '0;
  logic        rc_i = 1'b0, so_i = 1'b0;
  logic        valid_o, crf_we_o;
  logic [63:0] diff_o;
  logic [3:0]  crf_o;
  logic [2:0]  bf_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic        v;
    logic [1:0]  op;
    logic [63:0] diff;
    logic [3:0]  crf;
    logic [2:0]  bf;
    logic        we;
  } exp_t;

  exp_t  hist [3];
  string hist_tag [3];

  always #2 clk = ~clk;

  sc_alu i_sc_alu (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .dword_i(dword_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .bf_i(bf_i),
    .rc_i(rc_i), .so_i(so_i), .valid_o(valid_o), .diff_o(diff_o),
    .crf_o(crf_o), .bf_o(bf_o), .crf_we_o(crf_we_o)
  );

  function automatic logic [63:0] sx32(logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic exp_t model(logic v, logic [1:0] op, logic dw,
      logic [63:0] a, logic [63:0] b, logic [15:0] imm, logic [2:0] bf,
      logic rc, logic so);
    exp_t e;
    logic [63:0] x, y;
    x = a; y = b;
    if (op != 2'd0 && !dw) begin x = sx32(a); y = sx32(b); end
    if (op == 2'd2) y = {{48{imm[15]}}, imm};
    e.v = v; e.op = op; e.bf = bf;
    e.diff = y - x;
    if (op == 2'd0) begin
      e.crf = {e.diff[63], !e.diff[63] && e.diff != 0, e.diff == 0, so};
      e.we  = rc;
    end else if (op == 2'd3) begin
      e.crf = '0;
      e.we  = 1'b0;
    end else begin
      e.crf = {$signed(x) < $signed(y), $signed(x) > $signed(y), x == y, so};
      e.we  = 1'b1;
    end
    e.we = e.we && v;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_out();
    exp_t e;
    e = hist[2];
    if (!e.v) begin
      chk(valid_o == 1'b0, "R1", "idle valid", 64'(valid_o), 64'd0);
      chk(crf_we_o == 1'b0, "R11", "idle we", 64'(crf_we_o), 64'd0);
    end else begin
      chk(valid_o == 1'b1, "R1", "valid", 64'(valid_o), 64'd1);
      chk(crf_we_o == e.we, hist_tag[2], "we", 64'(crf_we_o), 64'(e.we));
      chk(bf_o == e.bf, "R8", "bf", 64'(bf_o), 64'(e.bf));
      if (e.op == 2'd0) chk(diff_o == e.diff, "R2", "diff", diff_o, e.diff);
      if (e.we) chk(crf_o == e.crf, hist_tag[2], "crf", 64'(crf_o), 64'(e.crf));
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic dw,
      input logic [63:0] a, input logic [63:0] b, input logic [15:0] imm,
      input logic [2:0] bf, input logic rc, input logic so, input string tag);
    @(negedge clk);
    check_out();
    hist[2] = hist[1]; hist_tag[2] = hist_tag[1];
    hist[1] = hist[0]; hist_tag[1] = hist_tag[0];
    hist[0] = model(v, op, dw, a, b, imm, bf, rc, so);
    hist_tag[0] = tag;
    valid_i = v; op_i = op; dword_i = dw; a_i = a; b_i = b;
    imm_i = imm; bf_i = bf; rc_i = rc; so_i = so;
  endtask

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;

  initial begin
    for (int i = 0; i < 3; i++) begin hist[i] = '0; hist_tag[i] = "R1"; end
    void'($urandom(32'd20240517));
    repeat (3) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R10", "reset valid", 64'(valid_o), 64'd0);
      chk(crf_we_o == 1'b0, "R10", "reset we", 64'(crf_we_o), 64'd0);
    end
    rst_ni = 1'b1;
    // directed corners
    step(1, 2'd0, 0, 64'd5, 64'd3, 0, 3'd1, 1, 0, "R3");    // negative result, mode ignored
    step(1, 2'd0, 1, 64'd7, 64'd7, 0, 3'd2, 1, 1, "R3");    // zero
    step(1, 2'd0, 1, 64'd1, 64'd9, 0, 3'd3, 0, 0, "R3");    // no record
    step(1, 2'd1, 1, 64'd4, 64'd4, 0, 3'd4, 0, 1, "R4");    // equal
    step(1, 2'd1, 1, MIN64, MAX64, 0, 3'd5, 0, 0, "R7");    // A<B, B-A overflows
    step(1, 2'd1, 1, MAX64, MIN64, 0, 3'd6, 0, 1, "R7");    // A>B, B-A overflows
    step(1, 2'd1, 0, 64'hFFFF_0000_0000_0001, 64'h0000_1234_FFFF_FFFF, 0, 3'd7, 0, 0, "R5");
    step(1, 2'd1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 3'd0, 0, 0, "R5");
    step(1, 2'd1, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 3'd1, 0, 0, "R5");
    step(1, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 16'hFFFF, 3'd2, 0, 0, "R6");
    step(1, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 16'hFFFF, 3'd3, 0, 1, "R6");
    step(1, 2'd2, 0, 64'h1234_5678_0000_0010, MAX64, 16'h0010, 3'd4, 0, 0, "R6");
    step(1, 2'd3, 1, 64'd1, 64'd2, 0, 3'd5, 1, 1, "R9");
    step(1, 2'd1, 1, 64'd1, 64'd2, 0, 3'd6, 1, 0, "R4");
    step(1, 2'd0, 1, 64'd2, 64'd1, 0, 3'd7, 1, 0, "R3");
    // seeded random stream, mostly back-to-back
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a, b;
      logic [1:0]  op;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a = 64'($signed($urandom_range(0, 16)) - 8);
      op = 2'($urandom_range(0, 3));
      step($urandom_range(0, 9) != 0, op, 1'($urandom), a, b, 16'($urandom),
           3'($urandom), 1'($urandom), 1'($urandom),
           op == 2'd0 ? "R3" : op == 2'd1 ? "R4" : op == 2'd2 ? "R6" : "R9");
    end
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule